// File: doc/BRIEF.md
# Burst Sample Capture Controller

The block sits between a free-running converter sample source and a stream-fed DMA engine. Software programs how many 64-bit beats it wants and raises an enable bit. The block then collects converter samples, packs four 16-bit samples into each 64-bit beat and streams exactly the requested number of beats over a valid/ready/last interface. After the final beat is accepted it returns to idle and waits for the next request.

Two sample formats are supported. In the single-channel format each valid sample cycle carries one signed 16-bit value. In the two-channel format each valid cycle carries a pair of 14-bit unsigned values, and each is widened to 16 bits with zeros. A three-bit status word reports whether a burst is running, whether a finished beat had to be dropped because the stream was still holding its predecessor, and whether the sample source paused in the middle of a burst.

Top module: `burst_cap`

## Requirements
- R1: The control word has the enable at bit 16 and the beat field in bits 15:0. A capture starts only when a control write takes the stored enable from 0 to 1. A write with bit 16 set while the stored enable is already 1 starts nothing.
- R2: A capture emits exactly (beat field + 1) beats, and `m_tlast` is high on the final beat only. Status bit 0 (busy) rises on the cycle after the starting write. Busy falls on the cycle after the last beat is accepted, and `m_tvalid` is never high while busy is low.
- R3: In the single-channel format four consecutive samples form one beat, with the earliest in bits 15:0 and the latest in bits 63:48.
- R4: In the two-channel format channel 0 is taken from `smp_data[13:0]` and channel 1 from `smp_data[29:16]`. Each is padded to 16 bits with zero upper bits. A beat holds lanes ch0, ch1, ch0, ch1 from bit 0 upward, taken from two consecutive sample cycles.
- R5: If a beat finishes packing while the output still holds an unaccepted beat, the new beat is dropped and status bit 1 (overflow) is set. The burst goes on with the beats that follow, so the count is still met.
- R6: Status bit 2 (underflow) is set when `smp_valid` is low after the burst's first sample was taken and before its final beat is packed. Waiting before the first sample does not set it.
- R7: Starting a capture clears both the overflow and the underflow flags.
- R8: A start write that arrives while busy is ignored, and the running burst keeps its original length.
- R9: Samples presented while idle, or after the final beat of a burst is packed, never appear in the output.
- R10: While `m_tvalid` is high and `m_tready` is low, the beat's data and last marker stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 17 | Control word: bit 16 enable, bits 15:0 beats minus one |
| mode_dual | input | 1 | Format select latched at start: 1 selects the two-channel format |
| stat_o | output | 3 | Status: bit 0 busy, bit 1 overflow, bit 2 underflow |
| smp_valid | input | 1 | Sample cycle strobe |
| smp_data | input | 32 | Sample bus: bits 15:0 single sample or channel 0, bits 29:16 channel 1 |
| m_tvalid | output | 1 | Beat valid |
| m_tready | input | 1 | Beat accepted by the sink |
| m_tdata | output | 64 | Packed beat |
| m_tlast | output | 1 | Final beat of the burst |

## Verification
The bench holds the sink off until a second beat completes behind an unaccepted first beat. A design that stalled the packer, or that counted the dropped beat, would then emit the wrong data or too few beats. It pauses the sample source both before the first sample and in mid-burst, so an underflow flag that ignores the first-sample rule would fire at start and one that misses stalls would stay clear. It also re-arms the enable while a burst runs and again after it ends. A level-triggered start or one that ignores busy would produce extra or longer bursts. Two-channel beats carry set upper bits on both channels to expose missing padding or swapped lanes.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int SMP_W    = 16;
  localparam int NARROW_W = 14;

  typedef struct packed {
    logic unf;
    logic ovf;
    logic busy;
  } bsc_stat_t;

  // zero the bits above the kept width of a narrow channel
  function automatic logic [SMP_W-1:0] pad_chan(input logic [SMP_W-1:0] raw, input int keep);
    logic [SMP_W-1:0] r;
    for (int i = 0; i < SMP_W; i++) r[i] = (i < keep) ? raw[i] : 1'b0;
    return r;
  endfunction

  // samples a single valid cycle contributes to a beat
  function automatic int lanes_per_take(input logic dual);
    return dual ? 2 : 1;
  endfunction
endpackage

// File: rtl/bsc_ctrl.sv
module bsc_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CNT_W:0]   cfg_wdata,
  input  logic             mode_dual,
  input  logic             drop_evt,
  input  logic             stall_evt,
  input  logic             done_evt,
  output logic             start_evt,
  output logic             busy_q,
  output logic             ovf_q,
  output logic             unf_q,
  output logic             dual_q,
  output logic [CNT_W-1:0] lim_q
);
  localparam int EN_BIT = CNT_W;

  logic en_q;

  assign start_evt = cfg_we && cfg_wdata[EN_BIT] && !en_q && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      dual_q <= 1'b0;
      lim_q  <= '0;
    end else begin
      if (cfg_we) en_q <= cfg_wdata[EN_BIT];
      if (start_evt) begin
        busy_q <= 1'b1;
        ovf_q  <= 1'b0;
        unf_q  <= 1'b0;
        dual_q <= mode_dual;
        lim_q  <= cfg_wdata[CNT_W-1:0];
      end else begin
        if (done_evt)  busy_q <= 1'b0;
        if (drop_evt)  ovf_q  <= 1'b1;
        if (stall_evt) unf_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsc_packer.sv
module bsc_packer
  import bsc_pkg::*;
#(
  parameter int SW     = SMP_W,
  parameter int NW     = NARROW_W,
  parameter int BEAT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              active,
  input  logic              dual,
  input  logic              smp_valid,
  input  logic [2*SW-1:0]   smp_data,
  output logic              beat_rdy,
  output logic [BEAT_W-1:0] beat_word,
  output logic              seen_q
);
  localparam int LANES  = BEAT_W / SW;
  localparam int LANE_W = $clog2(LANES);

  logic [LANE_W-1:0] lane_q;
  logic [BEAT_W-1:0] acc_q, acc_d;
  logic [SW-1:0]     s0, s1;
  logic [LANE_W:0]   step, sum;
  logic              take;

  assign take = active && smp_valid;
  assign s0   = dual ? pad_chan(smp_data[SW-1:0], NW) : smp_data[SW-1:0];
  assign s1   = pad_chan(smp_data[2*SW-1:SW], NW);
  assign step = (LANE_W+1)'(lanes_per_take(dual));
  assign sum  = {1'b0, lane_q} + step;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit0, hit1;
    assign hit0 = take && (lane_q == LANE_W'(g));
    if (g > 0) begin : g_pair
      assign hit1 = take && dual && (lane_q == LANE_W'(g - 1));
    end else begin : g_first
      assign hit1 = 1'b0;
    end
    assign acc_d[g*SW +: SW] = hit0 ? s0 : (hit1 ? s1 : acc_q[g*SW +: SW]);
  end

  assign beat_rdy  = take && (sum == (LANE_W+1)'(LANES));
  assign beat_word = acc_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q <= '0;
      acc_q  <= '0;
      seen_q <= 1'b0;
    end else if (clr) begin
      lane_q <= '0;
      seen_q <= 1'b0;
    end else if (take) begin
      seen_q <= 1'b1;
      acc_q  <= acc_d;
      lane_q <= beat_rdy ? '0 : sum[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/bsc_outstage.sv
module bsc_outstage #(
  parameter int CNT_W  = 16,
  parameter int BEAT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CNT_W-1:0]  lim,
  input  logic              beat_rdy,
  input  logic [BEAT_W-1:0] beat_word,
  input  logic              m_tready,
  output logic              m_tvalid,
  output logic [BEAT_W-1:0] m_tdata,
  output logic              m_tlast,
  output logic              drop_evt,
  output logic              more_q,
  output logic              done_evt
);
  logic [CNT_W:0] loaded_q;
  logic           load;

  assign more_q   = loaded_q <= {1'b0, lim};
  assign drop_evt = beat_rdy && m_tvalid && !m_tready;
  assign load     = beat_rdy && !drop_evt;
  assign done_evt = m_tvalid && m_tready && m_tlast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded_q <= '0;
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tlast  <= 1'b0;
    end else begin
      if (clr) loaded_q <= '0;
      else if (load) loaded_q <= loaded_q + 1'b1;
      if (load) begin
        m_tvalid <= 1'b1;
        m_tdata  <= beat_word;
        m_tlast  <= (loaded_q == {1'b0, lim});
      end else if (m_tvalid && m_tready) begin
        m_tvalid <= 1'b0;
        m_tlast  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/burst_cap.sv
module burst_cap
  import bsc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SW     = SMP_W,
  parameter int NW     = NARROW_W,
  parameter int BEAT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CNT_W:0]    cfg_wdata,
  input  logic              mode_dual,
  output logic [2:0]        stat_o,
  input  logic              smp_valid,
  input  logic [2*SW-1:0]   smp_data,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [BEAT_W-1:0] m_tdata,
  output logic              m_tlast
);
  logic             start_evt, drop_evt, stall_evt, done_evt;
  logic             busy_q, ovf_q, unf_q, dual_q, seen_q, more_q;
  logic             beat_rdy, active;
  logic [CNT_W-1:0] lim_q;
  logic [BEAT_W-1:0] beat_word;
  bsc_stat_t        st;

  assign active    = busy_q && more_q;
  assign stall_evt = active && seen_q && !smp_valid;

  bsc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mode_dual(mode_dual), .drop_evt(drop_evt), .stall_evt(stall_evt),
    .done_evt(done_evt), .start_evt(start_evt), .busy_q(busy_q),
    .ovf_q(ovf_q), .unf_q(unf_q), .dual_q(dual_q), .lim_q(lim_q)
  );

  bsc_packer #(.SW(SW), .NW(NW), .BEAT_W(BEAT_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(start_evt), .active(active),
    .dual(dual_q), .smp_valid(smp_valid), .smp_data(smp_data),
    .beat_rdy(beat_rdy), .beat_word(beat_word), .seen_q(seen_q)
  );

  bsc_outstage #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .clr(start_evt), .lim(lim_q),
    .beat_rdy(beat_rdy), .beat_word(beat_word), .m_tready(m_tready),
    .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast),
    .drop_evt(drop_evt), .more_q(more_q), .done_evt(done_evt)
  );

  assign st.busy = busy_q;
  assign st.ovf  = ovf_q;
  assign st.unf  = unf_q;
  assign stat_o  = st;
endmodule

// File: rtl/burst_cap_chk.sv
module burst_cap_chk #(
  parameter int CNT_W  = 16,
  parameter int BEAT_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              en_bit,
  input logic [2:0]        stat,
  input logic              tvalid,
  input logic              tready,
  input logic              tlast,
  input logic [BEAT_W-1:0] tdata,
  input logic              start_evt,
  input logic              drop_evt,
  input logic [CNT_W-1:0]  lim_q
);
  logic [CNT_W:0] hs_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) hs_cnt <= '0;
    else if (start_evt) hs_cnt <= '0;
    else if (tvalid && tready) hs_cnt <= hs_cnt + 1'b1;
  end

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> $past(cfg_we && en_bit)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !stat[0] |-> !tvalid); // R2
  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && tready && tlast) |=> !stat[0]); // R2
  AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && tready && tlast) |-> hs_cnt == {1'b0, lim_q}); // R2
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> stat[1]); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> stat[0] && !stat[1] && !stat[2]); // R7
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && !tready) |=> tvalid && $stable(tdata) && $stable(tlast)); // R10
endmodule

bind burst_cap burst_cap_chk #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .en_bit(cfg_wdata[CNT_W]),
  .stat(stat_o), .tvalid(m_tvalid), .tready(m_tready), .tlast(m_tlast),
  .tdata(m_tdata), .start_evt(start_evt), .drop_evt(drop_evt), .lim_q(lim_q)
);

// File: tb/tb_burst_cap.sv
`timescale 1ns/1ps
module tb_burst_cap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [16:0] cfg_wdata = '0;
  logic        mode_dual = 1'b0;
  logic [2:0]  stat_o;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic        m_tvalid;
  logic        m_tready = 1'b1;
  logic [63:0] m_tdata;
  logic        m_tlast;

  int n_chk = 0, n_bad = 0;

  // feeder controls
  bit feed_en = 0, feed_stall = 0, feed_dual = 0, feed_restart = 0;
  int feed_k = 0;

  // captured beats
  logic [63:0] cap_data [0:63];
  logic        cap_last [0:63];
  int          ncap = 0;

  always #10 clk = ~clk;

  burst_cap dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mode_dual(mode_dual), .stat_o(stat_o), .smp_valid(smp_valid),
    .smp_data(smp_data), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tlast(m_tlast)
  );

  function automatic logic [15:0] fv(input int k);
    return 16'h8001 + 16'(k) * 16'h0105;
  endfunction

  function automatic logic [63:0] exp_beat(input int first, input bit dual);
    logic [63:0] w;
    for (int l = 0; l < 4; l++)
      w[16*l +: 16] = dual ? {2'b00, fv(first + l)[13:0]} : fv(first + l);
    return w;
  endfunction

  // sample source
  initial begin
    forever begin
      @(posedge clk); #3;
      if (feed_restart) begin
        feed_k = 0;
        feed_restart = 0;
      end else if (smp_valid) begin
        feed_k += feed_dual ? 2 : 1;
      end
      if (feed_en && !feed_stall) begin
        smp_valid = 1'b1;
        smp_data  = feed_dual ? {2'b10, fv(feed_k + 1)[13:0], 2'b11, fv(feed_k)[13:0]}
                              : {16'hDEAD, fv(feed_k)};
      end else begin
        smp_valid = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (m_tvalid && m_tready && ncap < 64) begin
      cap_data[ncap] = m_tdata;
      cap_last[ncap] = m_tlast;
      ncap++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ctrl_write(input logic [16:0] w);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_wdata = w;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic start_cap(input logic [15:0] cnt, input bit dual);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_wdata = {1'b1, cnt}; mode_dual = dual;
    @(posedge clk); #2;
    cfg_we = 1'b0;
    ncap = 0;
    feed_dual = dual; feed_restart = 1; feed_en = 1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!stat_o[0]) break;
    end
    repeat (3) @(negedge clk);
    feed_en = 0;
  endtask

  task automatic check_burst(input string req, input int nexp, input bit dual,
                             input int b0, input int b1, input int stride);
    chk(ncap == nexp, req, "beat count", 64'(ncap), 64'(nexp));
    for (int j = 0; j < nexp && j < ncap; j++) begin
      int first = (j == 0) ? b0 : b1 + (j - 1) * stride;
      chk(cap_data[j] == exp_beat(first, dual), req, "beat data", cap_data[j], exp_beat(first, dual));
      chk(cap_last[j] == (j == nexp - 1), req, "last marker", 64'(cap_last[j]), 64'(j == nexp - 1));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(stat_o == 3'b000, "R2", "status after reset", 64'(stat_o), 64'd0);
    chk(m_tvalid == 1'b0, "R2", "valid after reset", 64'(m_tvalid), 64'd0);
  endtask

  // single format, samples offered while idle, stall before first sample
  task automatic t_single_basic();
    m_tready = 1;
    feed_dual = 0; feed_en = 1;
    repeat (6) @(posedge clk);
    feed_stall = 1;
    start_cap(16'd1, 1'b0);
    @(negedge clk);
    chk(stat_o[0] == 1'b1, "R2", "busy after start", 64'(stat_o), 64'd1);
    repeat (3) @(posedge clk);
    #2 feed_stall = 0;
    wait_idle();
    check_burst("R3", 2, 1'b0, 0, 4, 4);
    chk(stat_o == 3'b000, "R6", "no underflow before first sample", 64'(stat_o), 64'd0);
    chk(ncap == 2, "R9", "idle samples not emitted", 64'(ncap), 64'd2);
  endtask

  task automatic t_dual();
    m_tready = 1;
    ctrl_write(17'h0);
    start_cap(16'd2, 1'b1);
    wait_idle();
    check_burst("R4", 3, 1'b1, 0, 4, 4);
    chk(stat_o == 3'b000, "R4", "status after dual burst", 64'(stat_o), 64'd0);
  endtask

  task automatic t_overflow();
    m_tready = 0;
    ctrl_write(17'h0);
    start_cap(16'd1, 1'b0);
    repeat (9) @(posedge clk);
    #2;
    chk(stat_o[1] == 1'b1, "R5", "overflow set", 64'(stat_o), 64'h3);
    m_tready = 1;
    wait_idle();
    check_burst("R5", 2, 1'b0, 0, 8, 4);
    chk(stat_o == 3'b010, "R5", "overflow held at end", 64'(stat_o), 64'h2);
  endtask

  task automatic t_underflow();
    m_tready = 1;
    ctrl_write(17'h0);
    start_cap(16'd1, 1'b0);
    @(negedge clk);
    chk(stat_o == 3'b001, "R7", "flags cleared on start", 64'(stat_o), 64'h1);
    @(posedge clk); #2 feed_stall = 1;
    repeat (2) @(posedge clk);
    #2 feed_stall = 0;
    wait_idle();
    check_burst("R6", 2, 1'b0, 0, 4, 4);
    chk(stat_o == 3'b100, "R6", "underflow set by mid-burst stall", 64'(stat_o), 64'h4);
  endtask

  task automatic t_busy_restart();
    m_tready = 1;
    ctrl_write(17'h0);
    start_cap(16'd1, 1'b0);
    @(negedge clk);
    chk(stat_o == 3'b001, "R7", "underflow cleared on start", 64'(stat_o), 64'h1);
    ctrl_write(17'h0);
    ctrl_write({1'b1, 16'd5});
    wait_idle();
    check_burst("R8", 2, 1'b0, 0, 4, 4);
  endtask

  task automatic t_no_edge();
    ncap = 0;
    ctrl_write({1'b1, 16'd2});
    repeat (10) @(negedge clk);
    chk(stat_o[0] == 1'b0, "R1", "no start without enable edge", 64'(stat_o), 64'd0);
    chk(ncap == 0, "R1", "no beats without enable edge", 64'(ncap), 64'd0);
  endtask

  task automatic t_long();
    m_tready = 1;
    ctrl_write(17'h0);
    start_cap(16'd3, 1'b0);
    wait_idle();
    check_burst("R2", 4, 1'b0, 0, 4, 4);
    chk(stat_o == 3'b000, "R2", "idle after four beats", 64'(stat_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_single_basic();
    t_dual();
    t_overflow();
    t_underflow();
    t_busy_restart();
    t_no_edge();
    t_long();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule